// File: doc/BRIEF.md
# Pedestal Subtraction and Time-Bin Sorter

This block takes 10-bit samples from a link receiver, one per strobe, between a start-of-event and an end-of-event marker. Each sample is corrected by the pedestal of its channel and written as an 11-bit word to one of two external data SRAMs. The top bit of the word says whether the sample reached its pedestal, so a corrected value of zero is still stored and recognised. Header samples are flagged at the input, get a pedestal of zero, and fill a small region at the bottom of the SRAM.

Samples arrive in the same channel order in every time-bin round, so the k-th sample of each round always belongs to the same channel. The write address is built on the fly from counters so that all time bins of one channel land at consecutive addresses. A running adder steps from one channel's region to the next, so no lookup table or multiplier is needed. A small host register port loads the per-channel pedestals and the channel count and reads back the number of completed bin rounds. Ready, done and a 2-bit error code report the event state to the surrounding readout logic.

Top module: `ped_sorter`

## Requirements
- R1: A sample strobed with the header flag high is stored unchanged with bit 10 set (pedestal zero). Header samples take addresses 0, 1, 2, ... in arrival order. Header samples after the 32nd of an event are dropped and produce no write.
- R2: A data sample of channel c in bin round b is written to address 32 + 128*c + b. Channels are numbered 0 upward in arrival order within a round. A round ends after the number of channels held in the channel-count register, and the next sample then starts channel 0 of the next round.
- R3: Data word = {1, sample - pedestal} when sample >= pedestal. Otherwise it is all 11 bits zero.
- R4: The odd-select input is latched when an event is accepted. All writes of that event pulse oddWrite when it was 1 and evenWrite when it was 0. The two strobes are never high together.
- R5: A sample strobed in a given cycle is written by a one-cycle write strobe exactly two cycles later, with the address and data on both SRAM buses.
- R6: Register 00 loads a pedestal in two writes. The first write latches a channel address from the low data bits, and the second write stores the value at that address. A read of 00 returns the pedestal stored at the latched address and does not change the write phase.
- R7: Register 01 holds the channel count and can be read and written. A written value above 288 is stored as 288.
- R8: Register 10 reads the number of completed bin rounds of the current or last event, and a write to it has no effect. Register 11 always reads zero.
- R9: hostAck is high in the cycle after each cycle with hostSel high. Read data is valid while hostAck is high.
- R10: A host write to register 00 or 01 while an event is in progress changes nothing and sets errCode[1]. Both error bits clear when the next event is accepted.
- R11: An event start that arrives while an event is in progress is ignored and sets errCode[0].
- R12: readyOut falls in the cycle after an event is accepted, and doneOut clears in that cycle. When eventEnd is seen during an event, readyOut and doneOut rise three cycles later and stay high until the next event starts.
- R13: Sample strobes outside an event produce no SRAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 10 | Sample from link |
| sampleStrobe | input | 1 | Sample valid |
| headerFlag | input | 1 | Sample is a header word |
| eventStart | input | 1 | Start of event |
| eventEnd | input | 1 | End of event |
| oddSelect | input | 1 | Event goes to odd SRAM when high |
| evenAddr | output | 18 | Even SRAM address |
| evenData | output | 11 | Even SRAM write data |
| evenWrite | output | 1 | Even SRAM write strobe |
| oddAddr | output | 18 | Odd SRAM address |
| oddData | output | 11 | Odd SRAM write data |
| oddWrite | output | 1 | Odd SRAM write strobe |
| readyOut | output | 1 | A new event can be accepted |
| doneOut | output | 1 | Last event fully sorted |
| errCode | output | 2 | [0] start while busy, [1] rejected host write |
| hostSel | input | 1 | Host access this cycle |
| hostRead | input | 1 | Access is a read when high |
| hostAddr | input | 2 | Register select |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data |
| hostAck | output | 1 | Access acknowledge |

## Verification
A sample strobed in cycle n leaves on the SRAM strobes in cycle n+2: one register stage holds the address and the pedestal read, a second holds the corrected word. The bench therefore checks that no strobe is present one cycle after the sample and that the exact address and data are present the cycle after that. Host accesses complete in the cycle after select, so read data and the error bits are checked at that point. After eventEnd, ready and done are checked to be still low two cycles later and high three cycles later. All outputs are sampled on the falling edge, so these cycle counts fall between clock edges.

// File: rtl/ped_sorter_pkg.sv
package ped_sorter_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic evStart;    // event accepted: clear counters, latch target SRAM
    logic takeHdr;    // header sample accepted
    logic takeData;   // data sample accepted
    logic pedAddrWr;  // first pedestal write: latch address
    logic pedValWr;   // second pedestal write: store value
    logic chanWr;     // channel count write
    logic hostRd;     // register read
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_LAST  = 2'd3
  } sortState_t;
endpackage

// File: rtl/ped_sorter_ctrl.sv
module ped_sorter_ctrl
  import ped_sorter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         eventStart,
  input  logic         eventEnd,
  input  logic         sampleStrobe,
  input  logic         headerFlag,
  input  logic         hostSel,
  input  logic         hostRead,
  input  logic [1:0]   hostAddr,
  output ctrlStrobes_t strb,
  output logic         readyOut,
  output logic         doneOut,
  output logic [1:0]   errCode,
  output logic         hostAck
);
  sortState_t state;
  logic       pedPhase;
  logic       busy;
  logic       hostWr;
  logic       memWr;
  logic       accept;

  assign busy   = (state != ST_IDLE);
  assign hostWr = hostSel && !hostRead;
  assign memWr  = hostWr && (hostAddr == 2'b00 || hostAddr == 2'b01);
  assign accept = sampleStrobe && (state == ST_RUN);

  always_comb begin
    strb           = '0;
    strb.evStart   = eventStart && !busy;
    strb.takeHdr   = accept && headerFlag;
    strb.takeData  = accept && !headerFlag;
    strb.pedAddrWr = hostWr && !busy && hostAddr == 2'b00 && !pedPhase;
    strb.pedValWr  = hostWr && !busy && hostAddr == 2'b00 && pedPhase;
    strb.chanWr    = hostWr && !busy && hostAddr == 2'b01;
    strb.hostRd    = hostSel && hostRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pedPhase <= 1'b0;
      doneOut  <= 1'b0;
      errCode  <= 2'b00;
      hostAck  <= 1'b0;
    end else begin
      hostAck <= hostSel;
      if (strb.pedAddrWr) pedPhase <= 1'b1;
      if (strb.pedValWr)  pedPhase <= 1'b0;
      if (busy && memWr)  errCode[1] <= 1'b1;
      if (busy && eventStart) errCode[0] <= 1'b1;
      unique case (state)
        ST_IDLE: if (eventStart) begin
          state   <= ST_RUN;
          doneOut <= 1'b0;
          errCode <= 2'b00;
        end
        ST_RUN:   if (eventEnd) state <= ST_FLUSH;
        ST_FLUSH: state <= ST_LAST;
        ST_LAST: begin
          state   <= ST_IDLE;
          doneOut <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign readyOut = !busy;
endmodule

// File: rtl/ped_sorter_datapath.sv
module ped_sorter_datapath
  import ped_sorter_pkg::*;
#(
  parameter int SMP_W     = 10,
  parameter int ADDR_W    = 18,
  parameter int HOST_W    = 16,
  parameter int HDR_SLOTS = 32,
  parameter int BIN_SLOTS = 128,
  parameter int PED_DEPTH = 288
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [SMP_W-1:0]  sampleIn,
  input  logic              oddSelect,
  input  logic [1:0]        hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [SMP_W:0]    memData,
  output logic              evenWe,
  output logic              oddWe
);
  localparam int RES_W = SMP_W + 1;
  localparam int CH_W  = $clog2(PED_DEPTH + 1);
  localparam int BIN_W = $clog2(BIN_SLOTS + 1);
  localparam int HDR_W = $clog2(HDR_SLOTS + 1);
  localparam logic [ADDR_W-1:0] DATA_BASE = ADDR_W'(HDR_SLOTS);
  localparam logic [ADDR_W-1:0] STRIDE    = ADDR_W'(BIN_SLOTS);

  logic [RES_W-1:0]  pedMem [PED_DEPTH];
  logic [CH_W-1:0]   pedAddr;
  logic [CH_W-1:0]   numChans;
  logic [CH_W-1:0]   chIdx;
  logic [ADDR_W-1:0] chBase;
  logic [BIN_W-1:0]  binIdx;
  logic [HDR_W-1:0]  hdrIdx;
  logic              oddLatch;

  logic              hdrOk, dataOk, lastCh;
  logic              aValid, aHdr;
  logic [SMP_W-1:0]  aSample;
  logic [ADDR_W-1:0] aAddr;
  logic [RES_W-1:0]  pedQ;
  logic [RES_W-1:0]  pedUse;
  logic [RES_W-1:0]  result;
  logic              wrValid, wrOdd;

  assign hdrOk  = strb.takeHdr && (hdrIdx < HDR_W'(HDR_SLOTS));
  assign dataOk = strb.takeData && (binIdx < BIN_W'(BIN_SLOTS));
  assign lastCh = (CH_W'(chIdx + 1'b1) >= numChans);

  // pedestal memory, written only by the host outside events
  always_ff @(posedge clk) begin
    if (strb.pedValWr && pedAddr < CH_W'(PED_DEPTH))
      pedMem[pedAddr] <= hostWdata[RES_W-1:0];
  end

  // configuration and sort counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pedAddr  <= '0;
      numChans <= CH_W'(1);
      chIdx    <= '0;
      chBase   <= DATA_BASE;
      binIdx   <= '0;
      hdrIdx   <= '0;
      oddLatch <= 1'b0;
    end else begin
      if (strb.pedAddrWr) pedAddr <= hostWdata[CH_W-1:0];
      if (strb.chanWr)
        numChans <= (hostWdata > HOST_W'(PED_DEPTH)) ? CH_W'(PED_DEPTH)
                                                      : hostWdata[CH_W-1:0];
      if (strb.evStart) begin
        chIdx    <= '0;
        chBase   <= DATA_BASE;
        binIdx   <= '0;
        hdrIdx   <= '0;
        oddLatch <= oddSelect;
      end else begin
        if (hdrOk) hdrIdx <= hdrIdx + 1'b1;
        if (dataOk) begin
          if (lastCh) begin
            chIdx  <= '0;
            chBase <= DATA_BASE;
            binIdx <= binIdx + 1'b1;
          end else begin
            chIdx  <= chIdx + 1'b1;
            chBase <= chBase + STRIDE;
          end
        end
      end
    end
  end

  // stage A: address formed, pedestal fetched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aValid  <= 1'b0;
      aHdr    <= 1'b0;
      aSample <= '0;
      aAddr   <= '0;
      pedQ    <= '0;
    end else begin
      aValid <= hdrOk || dataOk;
      if (hdrOk || dataOk) begin
        aHdr    <= hdrOk;
        aSample <= sampleIn;
        aAddr   <= hdrOk ? ADDR_W'(hdrIdx) : (chBase + ADDR_W'(binIdx));
        pedQ    <= (chIdx < CH_W'(PED_DEPTH)) ? pedMem[chIdx] : '0;
      end
    end
  end

  // stage B: saturating subtraction and write strobe
  assign pedUse = aHdr ? '0 : pedQ;

  always_comb begin
    if ({1'b0, aSample} >= pedUse)
      result = {1'b1, aSample - pedUse[SMP_W-1:0]};
    else
      result = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrOdd   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      wrValid <= aValid;
      if (aValid) begin
        wrOdd   <= oddLatch;
        memAddr <= aAddr;
        memData <= result;
      end
    end
  end

  assign evenWe = wrValid && !wrOdd;
  assign oddWe  = wrValid && wrOdd;

  // host readback
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (strb.hostRd) begin
      unique case (hostAddr)
        2'b00: hostRdata <= (pedAddr < CH_W'(PED_DEPTH)) ? HOST_W'(pedMem[pedAddr]) : '0;
        2'b01: hostRdata <= HOST_W'(numChans);
        2'b10: hostRdata <= HOST_W'(binIdx);
        default: hostRdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ped_sorter.sv
module ped_sorter
  import ped_sorter_pkg::*;
#(
  parameter int SMP_W     = 10,
  parameter int ADDR_W    = 18,
  parameter int HOST_W    = 16,
  parameter int HDR_SLOTS = 32,
  parameter int BIN_SLOTS = 128,
  parameter int PED_DEPTH = 288
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SMP_W-1:0]  sampleIn,
  input  logic              sampleStrobe,
  input  logic              headerFlag,
  input  logic              eventStart,
  input  logic              eventEnd,
  input  logic              oddSelect,
  output logic [ADDR_W-1:0] evenAddr,
  output logic [SMP_W:0]    evenData,
  output logic              evenWrite,
  output logic [ADDR_W-1:0] oddAddr,
  output logic [SMP_W:0]    oddData,
  output logic              oddWrite,
  output logic              readyOut,
  output logic              doneOut,
  output logic [1:0]        errCode,
  input  logic              hostSel,
  input  logic              hostRead,
  input  logic [1:0]        hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  output logic              hostAck
);
  ctrlStrobes_t      strb;
  logic [ADDR_W-1:0] memAddr;
  logic [SMP_W:0]    memData;

  ped_sorter_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .eventStart   (eventStart),
    .eventEnd     (eventEnd),
    .sampleStrobe (sampleStrobe),
    .headerFlag   (headerFlag),
    .hostSel      (hostSel),
    .hostRead     (hostRead),
    .hostAddr     (hostAddr),
    .strb         (strb),
    .readyOut     (readyOut),
    .doneOut      (doneOut),
    .errCode      (errCode),
    .hostAck      (hostAck)
  );

  ped_sorter_datapath #(
    .SMP_W     (SMP_W),
    .ADDR_W    (ADDR_W),
    .HOST_W    (HOST_W),
    .HDR_SLOTS (HDR_SLOTS),
    .BIN_SLOTS (BIN_SLOTS),
    .PED_DEPTH (PED_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sampleIn  (sampleIn),
    .oddSelect (oddSelect),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .memAddr   (memAddr),
    .memData   (memData),
    .evenWe    (evenWrite),
    .oddWe     (oddWrite)
  );

  assign evenAddr = memAddr;
  assign evenData = memData;
  assign oddAddr  = memAddr;
  assign oddData  = memData;
endmodule

// File: rtl/ped_sorter_chk.sv
module ped_sorter_chk #(
  parameter int SMP_W = 10
) (
  input logic           clk,
  input logic           rstN,
  input logic           eventStart,
  input logic           eventEnd,
  input logic           sampleStrobe,
  input logic           evenWrite,
  input logic           oddWrite,
  input logic [SMP_W:0] evenData,
  input logic           readyOut,
  input logic           doneOut,
  input logic [1:0]     errCode,
  input logic           hostSel,
  input logic           hostRead,
  input logic [1:0]     hostAddr,
  input logic           hostAck
);
  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(evenWrite && oddWrite));

  // R3
  sat_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evenWrite && !evenData[SMP_W]) |-> (evenData[SMP_W-1:0] == '0));

  // R9
  ack_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostSel |=> hostAck);

  // R10
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && hostSel && !hostRead && hostAddr[1] == 1'b0) |=> errCode[1]);

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && eventStart) |=> errCode[0]);

  // R12
  start_busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && eventStart) |=> (!readyOut && !doneOut));

  // R12
  done_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> readyOut);

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && sampleStrobe) |=> ##1 !(evenWrite || oddWrite));

  // R12
  end_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && $past(!readyOut) && eventEnd) |=> !readyOut);
endmodule

bind ped_sorter ped_sorter_chk #(.SMP_W(SMP_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .eventStart   (eventStart),
  .eventEnd     (eventEnd),
  .sampleStrobe (sampleStrobe),
  .evenWrite    (evenWrite),
  .oddWrite     (oddWrite),
  .evenData     (evenData),
  .readyOut     (readyOut),
  .doneOut      (doneOut),
  .errCode      (errCode),
  .hostSel      (hostSel),
  .hostRead     (hostRead),
  .hostAddr     (hostAddr),
  .hostAck      (hostAck)
);

// File: tb/ped_sorter_bench.sv
module ped_sorter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  sampleIn = '0;
  logic        sampleStrobe = 1'b0;
  logic        headerFlag = 1'b0;
  logic        eventStart = 1'b0;
  logic        eventEnd = 1'b0;
  logic        oddSelect = 1'b0;
  logic [17:0] evenAddr, oddAddr;
  logic [10:0] evenData, oddData;
  logic        evenWrite, oddWrite;
  logic        readyOut, doneOut;
  logic [1:0]  errCode;
  logic        hostSel = 1'b0;
  logic        hostRead = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        hostAck;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ped_sorter u_ped_sorter (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleStrobe(sampleStrobe),
    .headerFlag(headerFlag), .eventStart(eventStart), .eventEnd(eventEnd),
    .oddSelect(oddSelect), .evenAddr(evenAddr), .evenData(evenData),
    .evenWrite(evenWrite), .oddAddr(oddAddr), .oddData(oddData),
    .oddWrite(oddWrite), .readyOut(readyOut), .doneOut(doneOut),
    .errCode(errCode), .hostSel(hostSel), .hostRead(hostRead),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostAck(hostAck)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostRead = 1'b0; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0;
    check("R9 write ack", 32'(hostAck), 32'd1);
  endtask

  task automatic hostGet(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostRead = 1'b1; hostAddr = a;
    @(negedge clk);
    hostSel = 1'b0; hostRead = 1'b0;
    check("R9 read ack", 32'(hostAck), 32'd1);
    d = hostRdata;
  endtask

  // strobe one sample, verify nothing one cycle later and the write two cycles later
  task automatic sendSample(input string req, input logic hdr, input logic [9:0] v,
                            input logic expWr, input logic expOdd,
                            input logic [17:0] expA, input logic [10:0] expD);
    @(negedge clk);
    sampleIn = v; headerFlag = hdr; sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0; headerFlag = 1'b0;
    check({req, " R5 early"}, 32'(evenWrite | oddWrite), 32'd0);
    @(negedge clk);
    if (!expWr) begin
      check({req, " no write"}, 32'(evenWrite | oddWrite), 32'd0);
    end else if (expOdd) begin
      check({req, " R4 odd strobe"}, {evenWrite, oddWrite}, 32'b01);
      check({req, " addr"}, 32'(oddAddr), 32'(expA));
      check({req, " data"}, 32'(oddData), 32'(expD));
    end else begin
      check({req, " R4 even strobe"}, {evenWrite, oddWrite}, 32'b10);
      check({req, " addr"}, 32'(evenAddr), 32'(expA));
      check({req, " data"}, 32'(evenData), 32'(expD));
    end
  endtask

  task automatic startEvent(input logic odd);
    @(negedge clk);
    eventStart = 1'b1; oddSelect = odd;
    @(negedge clk);
    eventStart = 1'b0;
    check("R12 ready low after start", 32'(readyOut), 32'd0);
    check("R12 done cleared", 32'(doneOut), 32'd0);
    check("R10 R11 errors cleared", 32'(errCode), 32'd0);
  endtask

  task automatic endEvent();
    @(negedge clk);
    eventEnd = 1'b1;
    @(negedge clk);
    eventEnd = 1'b0;
    @(negedge clk);
    check("R12 still busy", 32'(readyOut), 32'd0);
    check("R12 done not yet", 32'(doneOut), 32'd0);
    @(negedge clk);
    check("R12 ready", 32'(readyOut), 32'd1);
    check("R12 done", 32'(doneOut), 32'd1);
  endtask

  task automatic testReset();
    check("R12 reset ready", 32'(readyOut), 32'd1);
    check("R12 reset done", 32'(doneOut), 32'd0);
    check("R10 reset err", 32'(errCode), 32'd0);
    check("R5 reset strobes", 32'(evenWrite | oddWrite), 32'd0);
  endtask

  task automatic testConfig();
    logic [15:0] r;
    hostWrite(2'b00, 16'd0); hostWrite(2'b00, 16'd100);
    hostWrite(2'b00, 16'd2); hostWrite(2'b00, 16'd200);
    hostWrite(2'b00, 16'd1); hostWrite(2'b00, 16'd5);
    hostGet(2'b00, r);
    check("R6 readback latched addr", 32'(r), 32'd5);
    hostGet(2'b00, r);
    check("R6 read keeps phase", 32'(r), 32'd5);
    hostWrite(2'b01, 16'd500);
    hostGet(2'b01, r);
    check("R7 clamp", 32'(r), 32'd288);
    hostWrite(2'b01, 16'd3);
    hostGet(2'b01, r);
    check("R7 channel count", 32'(r), 32'd3);
    hostWrite(2'b10, 16'd7);
    hostGet(2'b10, r);
    check("R8 bins read-only", 32'(r), 32'd0);
    hostWrite(2'b11, 16'h1234);
    hostGet(2'b11, r);
    check("R8 reserved zero", 32'(r), 32'd0);
  endtask

  task automatic testEvenEvent();
    logic [15:0] r;
    startEvent(1'b0);
    sendSample("R1 hdr0", 1'b1, 10'h155, 1'b1, 1'b0, 18'd0, 11'h555);
    sendSample("R1 hdr1", 1'b1, 10'h000, 1'b1, 1'b0, 18'd1, 11'h400);
    sendSample("R2 R3 ch0b0", 1'b0, 10'd150, 1'b1, 1'b0, 18'd32, 11'h400 | 11'd50);
    sendSample("R2 R3 ch1b0 below", 1'b0, 10'd3, 1'b1, 1'b0, 18'd160, 11'd0);
    sendSample("R2 R3 ch2b0", 1'b0, 10'd900, 1'b1, 1'b0, 18'd288, 11'h400 | 11'd700);
    sendSample("R2 R3 ch0b1 equal", 1'b0, 10'd100, 1'b1, 1'b0, 18'd33, 11'h400);
    sendSample("R2 R3 ch1b1", 1'b0, 10'd1023, 1'b1, 1'b0, 18'd161, 11'h400 | 11'd1018);
    sendSample("R2 R3 ch2b1 below", 1'b0, 10'd199, 1'b1, 1'b0, 18'd289, 11'd0);
    // R10: writes rejected during the event
    hostWrite(2'b00, 16'd0);
    check("R10 err set", 32'(errCode[1]), 32'd1);
    hostWrite(2'b01, 16'd9);
    // R11: second start ignored
    @(negedge clk); eventStart = 1'b1;
    @(negedge clk); eventStart = 1'b0;
    check("R11 err set", 32'(errCode[0]), 32'd1);
    check("R11 still busy", 32'(readyOut), 32'd0);
    sendSample("R11 counters kept ch0b2", 1'b0, 10'd101, 1'b1, 1'b0, 18'd34, 11'h401);
    endEvent();
    hostGet(2'b10, r);
    check("R8 bin rounds", 32'(r), 32'd2);
    hostGet(2'b01, r);
    check("R10 chans unchanged", 32'(r), 32'd3);
    hostGet(2'b00, r);
    check("R10 ped unchanged", 32'(r), 32'd5);
    hostWrite(2'b00, 16'd0);
    hostGet(2'b00, r);
    check("R10 phase unchanged", 32'(r), 32'd100);
    hostWrite(2'b00, 16'd100);
  endtask

  task automatic testIdleSample();
    sendSample("R13 idle sample", 1'b0, 10'd500, 1'b0, 1'b0, 18'd0, 11'd0);
  endtask

  task automatic testOddEvent();
    startEvent(1'b1);
    for (int i = 0; i < 32; i++)
      sendSample("R1 hdr fill", 1'b1, 10'(i + 7), 1'b1, 1'b1, 18'(i), 11'h400 | 11'(i + 7));
    sendSample("R1 hdr overflow", 1'b1, 10'h3ff, 1'b0, 1'b1, 18'd0, 11'd0);
    sendSample("R2 R4 odd ch0b0", 1'b0, 10'd300, 1'b1, 1'b1, 18'd32, 11'h400 | 11'd200);
    endEvent();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testEvenEvent();
    testIdleSample();
    testOddEvent();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule